// File: doc/BRIEF.md
# Post-Increment Zero-Extending Load Unit

This unit executes one load at a time on a 64-bit register machine, using post-increment addressing. A decoded operation arrives with four pieces of information: the access size (byte or halfword), the offset form (signed immediate displacement or index register), the destination and base register numbers, and the current values of the base register, the index register and the displacement.

The unit sends a single read to a simple memory port. The address of that read is the base value exactly as it was presented. When the response comes back, the unit presents two register writebacks in the same cycle. The first is the loaded data, zero-extended to 64 bits, for the destination register. The second is the base plus the offset, for the base register.

An operation that names the same register as both destination and base is an invalid form. The unit flags it, and it causes no memory access and no writeback. The unit takes a new operation only while idle.

Top module: `pinc_load_unit`

## Requirements
- R1: After an operation is accepted, `mem_req` is high for exactly one cycle. During that cycle `mem_addr` equals the base value `op_ra_val` captured at acceptance, with nothing added, and `mem_half` equals the requested size (1 = halfword, 0 = byte).
- R2: For a byte load, bits 7:0 of `wb_rt_data` equal `mem_rdata[7:0]` and bits 63:8 are zero. `mem_rdata[15:8]` has no effect on the result.
- R3: For a halfword load, bits 15:0 of `wb_rt_data` equal `mem_rdata[15:0]` and bits 63:16 are zero. Memory places the byte at the lower address in `mem_rdata[15:8]`.
- R4: In the immediate form (`op_indexed`=0), `wb_ra_data` equals the captured base plus `op_disp` sign-extended from 16 to 64 bits.
- R5: In the indexed form (`op_indexed`=1), `wb_ra_data` equals the captured base plus `op_rb_val`.
- R6: The base update wraps modulo 2^64 in both directions.
- R7: An operation with `op_rt` equal to `op_ra` is accepted and answered by a one-cycle `illegal` pulse in the following cycle. It produces no `mem_req` and no `wb_valid`.
- R8: `op_ready` is high only while the unit is idle. An operation offered while the unit is busy is not taken, and it causes no later memory request.
- R9: `wb_valid` is high for exactly one cycle, starting in the cycle after `mem_rvalid` is seen. In that cycle `wb_rt_idx` and `wb_ra_idx` carry the register numbers of the operation. `op_ready` is high again in the next cycle.
- R10: While and after reset, with no operation offered, `op_ready` is 1 and `mem_req`, `wb_valid` and `illegal` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Unit idle, operation will be taken |
| op_half | input | 1 | 1 = halfword, 0 = byte |
| op_indexed | input | 1 | 1 = offset from index register, 0 = displacement |
| op_rt | input | 5 | Destination register number |
| op_ra | input | 5 | Base register number |
| op_ra_val | input | 64 | Base register value |
| op_rb_val | input | 64 | Index register value |
| op_disp | input | 16 | Signed displacement |
| mem_req | output | 1 | Read request, one cycle |
| mem_addr | output | 64 | Read address |
| mem_half | output | 1 | Read size, 1 = halfword |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 16 | Read data, lower-address byte in bits 15:8 |
| wb_valid | output | 1 | Both writebacks presented |
| wb_rt_idx | output | 5 | Destination register number |
| wb_rt_data | output | 64 | Zero-extended loaded value |
| wb_ra_idx | output | 5 | Base register number |
| wb_ra_data | output | 64 | Updated base value |
| illegal | output | 1 | Invalid-form pulse |

## Verification
The hardest condition to create from the ports is an operation offered while an earlier one is still in flight. The stimulus for it keeps `op_valid` high, with a different base value, through a multi-cycle response wait. It releases `op_valid` only in the writeback cycle, and then watches for the memory request that must not follow. Response latencies from zero to three wait cycles vary the point at which `mem_rvalid` arrives. Base values near zero and near the top of the address space, combined with negative displacements and index values, force the base update to wrap.

// File: rtl/pinc_load_unit.sv
module pinc_load_unit #(
  parameter int XLEN   = 64,
  parameter int RIDX_W = 5,
  parameter int DISP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic              op_half,
  input  logic              op_indexed,
  input  logic [RIDX_W-1:0] op_rt,
  input  logic [RIDX_W-1:0] op_ra,
  input  logic [XLEN-1:0]   op_ra_val,
  input  logic [XLEN-1:0]   op_rb_val,
  input  logic [DISP_W-1:0] op_disp,
  output logic              mem_req,
  output logic [XLEN-1:0]   mem_addr,
  output logic              mem_half,
  input  logic              mem_rvalid,
  input  logic [15:0]       mem_rdata,
  output logic              wb_valid,
  output logic [RIDX_W-1:0] wb_rt_idx,
  output logic [XLEN-1:0]   wb_rt_data,
  output logic [RIDX_W-1:0] wb_ra_idx,
  output logic [XLEN-1:0]   wb_ra_data,
  output logic              illegal
);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT, S_DONE} state_t;

  state_t            state;
  logic              half_q, illegal_q;
  logic [RIDX_W-1:0] rt_q, ra_q;
  logic [XLEN-1:0]   base_q, sum_q;
  logic [15:0]       data_q;

  wire              take   = op_valid && op_ready;
  wire              clash  = (op_rt == op_ra);
  wire [XLEN-1:0]   offset = op_indexed ? op_rb_val
                                        : {{(XLEN-DISP_W){op_disp[DISP_W-1]}}, op_disp};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      illegal_q <= 1'b0;
      half_q    <= 1'b0;
      rt_q      <= '0;
      ra_q      <= '0;
      base_q    <= '0;
      sum_q     <= '0;
      data_q    <= '0;
    end else begin
      illegal_q <= take && clash;
      case (state)
        S_IDLE: if (take && !clash) begin
          state  <= S_REQ;
          half_q <= op_half;
          rt_q   <= op_rt;
          ra_q   <= op_ra;
          base_q <= op_ra_val;
          sum_q  <= op_ra_val + offset;
        end
        S_REQ:  state <= S_WAIT;
        S_WAIT: if (mem_rvalid) begin
          data_q <= mem_rdata;
          state  <= S_DONE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign op_ready   = (state == S_IDLE);
  assign mem_req    = (state == S_REQ);
  assign mem_addr   = base_q;
  assign mem_half   = half_q;
  assign wb_valid   = (state == S_DONE);
  assign wb_rt_idx  = rt_q;
  assign wb_ra_idx  = ra_q;
  assign wb_ra_data = sum_q;
  assign wb_rt_data = half_q ? {{(XLEN-16){1'b0}}, data_q}
                             : {{(XLEN-8){1'b0}}, data_q[7:0]};
  assign illegal    = illegal_q;

  p_req_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
  p_byte_zext_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !mem_half) |-> (wb_rt_data[XLEN-1:8] == '0));
  p_half_zext_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (wb_rt_data[XLEN-1:16] == '0));
  p_illegal_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!mem_req && !wb_valid));
  p_illegal_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> !illegal);
  p_busy_not_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req || wb_valid) |-> !op_ready);
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |=> (!wb_valid && op_ready));
  p_done_after_resp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wb_valid) |-> $past(mem_rvalid));

endmodule

// File: tb/test_pinc_load_unit.sv
module test_pinc_load_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0, op_half = 1'b0, op_indexed = 1'b0;
  logic [4:0]  op_rt = '0, op_ra = '0;
  logic [63:0] op_ra_val = '0, op_rb_val = '0;
  logic [15:0] op_disp = '0;
  logic        mem_rvalid = 1'b0;
  logic [15:0] mem_rdata = '0;
  logic        op_ready, mem_req, mem_half, wb_valid, illegal;
  logic [63:0] mem_addr, wb_rt_data, wb_ra_data;
  logic [4:0]  wb_rt_idx, wb_ra_idx;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  pinc_load_unit i_pinc_load_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_half(op_half), .op_indexed(op_indexed), .op_rt(op_rt), .op_ra(op_ra),
    .op_ra_val(op_ra_val), .op_rb_val(op_rb_val), .op_disp(op_disp),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_half(mem_half),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .wb_valid(wb_valid), .wb_rt_idx(wb_rt_idx), .wb_rt_data(wb_rt_data),
    .wb_ra_idx(wb_ra_idx), .wb_ra_data(wb_ra_data), .illegal(illegal)
  );

  typedef struct packed {
    logic        half;
    logic        idx;
    logic [63:0] ra;
    logic [63:0] rb;
    logic [15:0] d;
    logic [15:0] rdata;
    logic [3:0]  lat;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 64'h1000, 64'h0, 16'h0008, 16'hEEA5, 4'd0},
    '{1'b1, 1'b0, 64'h2000, 64'h0, 16'hFFFE, 16'h1234, 4'd2},
    '{1'b0, 1'b1, 64'h3000, 64'h40, 16'h0000, 16'h7F80, 4'd1},
    '{1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFF0, 64'h20, 16'h0000, 16'hBEEF, 4'd3},
    '{1'b1, 1'b0, 64'h4, 64'h0, 16'h8000, 16'h8001, 4'd0},
    '{1'b0, 1'b1, 64'h100, 64'hFFFF_FFFF_FFFF_FF00, 16'h0000, 16'h00FF, 4'd1}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_op(input vec_t v, input logic [4:0] rt, input logic [4:0] ra,
                        input bit poke);
    logic [63:0] exp_rt, exp_ra;
    exp_rt = v.half ? {48'h0, v.rdata} : {56'h0, v.rdata[7:0]};
    exp_ra = v.ra + (v.idx ? v.rb : {{48{v.d[15]}}, v.d});
    @(negedge clk);
    op_valid = 1'b1; op_half = v.half; op_indexed = v.idx;
    op_rt = rt; op_ra = ra; op_ra_val = v.ra; op_rb_val = v.rb; op_disp = v.d;
    @(negedge clk);
    op_valid = 1'b0;
    chk(mem_req == 1'b1, "R1 req", {63'h0, mem_req}, 64'h1);
    chk(mem_addr == v.ra, "R1 addr", mem_addr, v.ra);
    chk(mem_half == v.half, "R1 size", {63'h0, mem_half}, {63'h0, v.half});
    @(negedge clk);
    chk(mem_req == 1'b0, "R1 single req", {63'h0, mem_req}, 64'h0);
    for (int k = 0; k < int'(v.lat); k++) begin
      if (poke) begin
        op_valid = 1'b1; op_ra_val = ~v.ra; op_rt = rt + 5'd1;
        chk(op_ready == 1'b0, "R8 busy", {63'h0, op_ready}, 64'h0);
      end
      @(negedge clk);
    end
    mem_rvalid = 1'b1;
    mem_rdata  = v.rdata;
    @(negedge clk);
    mem_rvalid = 1'b0;
    op_valid   = 1'b0;
    mem_rdata  = 16'hDEAD;
    chk(wb_valid == 1'b1, "R9 done", {63'h0, wb_valid}, 64'h1);
    chk(wb_rt_data == exp_rt, v.half ? "R3 half data" : "R2 byte data", wb_rt_data, exp_rt);
    chk(wb_ra_data == exp_ra, v.idx ? "R5/R6 indexed update" : "R4/R6 imm update",
        wb_ra_data, exp_ra);
    chk(wb_rt_idx == rt && wb_ra_idx == ra, "R9 indices",
        {54'h0, wb_rt_idx, wb_ra_idx}, {54'h0, rt, ra});
    @(negedge clk);
    chk(wb_valid == 1'b0, "R9 done pulse", {63'h0, wb_valid}, 64'h0);
    chk(op_ready == 1'b1, "R9 ready again", {63'h0, op_ready}, 64'h1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got %h expected %h", 64'h0, 64'h1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int reqs;
    repeat (3) @(negedge clk);
    chk(op_ready && !mem_req && !wb_valid && !illegal, "R10 in reset",
        {60'h0, op_ready, mem_req, wb_valid, illegal}, 64'h8);
    rst_n = 1'b1;
    @(negedge clk);
    chk(op_ready && !mem_req && !wb_valid && !illegal, "R10 after reset",
        {60'h0, op_ready, mem_req, wb_valid, illegal}, 64'h8);

    for (int i = 0; i < NV; i++)
      run_op(VECS[i], 5'(i + 1), 5'(i + 10), 1'b0);

    // R8: offer a second operation throughout a busy period
    run_op(VECS[1], 5'd3, 5'd4, 1'b1);
    reqs = 0;
    repeat (3) begin
      @(negedge clk);
      if (mem_req) reqs++;
    end
    chk(reqs == 0, "R8 no late request", 64'(reqs), 64'h0);

    // R7: destination equals base
    @(negedge clk);
    op_valid = 1'b1; op_half = 1'b1; op_indexed = 1'b0;
    op_rt = 5'd7; op_ra = 5'd7; op_ra_val = 64'h5000; op_disp = 16'h2;
    @(negedge clk);
    op_valid = 1'b0;
    chk(illegal == 1'b1, "R7 flag", {63'h0, illegal}, 64'h1);
    chk(!mem_req && !wb_valid, "R7 no access", {62'h0, mem_req, wb_valid}, 64'h0);
    reqs = 0;
    repeat (3) begin
      @(negedge clk);
      if (mem_req || wb_valid || illegal) reqs++;
    end
    chk(reqs == 0, "R7 quiet after pulse", 64'(reqs), 64'h0);

    run_op(VECS[0], 5'd2, 5'd3, 1'b0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule